// File: doc/BRIEF.md
# Synchronous Burst SRAM Core

This block is a small synchronous static memory with an internal burst address generator. Each access is sampled on the rising clock edge. An access either takes a fresh external address or continues the current burst. A burst begins when either of two address strobes is seen with chip enable high. Later accesses in the burst are formed inside the block, and the two low address bits step only in cycles where the advance input is high. A mode input chooses the stepping order. Linear order adds the step count to the loaded low bits, modulo four. Interleaved order XORs the step count with them. The burst function is optional: a new external address may be strobed in on every cycle with no loss of throughput.

Writes can be global, which writes every byte lane, or per byte, where a byte-write enable is qualified by one select bit per lane. A read can be flow-through or pipelined. In flow-through mode the data comes out of the array directly during the cycle after the sampling edge. In pipelined mode it passes through an output register and arrives one cycle later. Output enable is asynchronous. While it is low, the data bus is released. This is modelled as a cleared valid flag and zeroed data, not as a tri-state pin.

The memory side is a plain control interface and not a valid/ready stream. The memory can never stall, so there is no back-pressure. The `rvalid` flag only marks the cycles in which `rdata` carries read data. The mode inputs must be tied when the block is placed. For the default behaviour, tie `lin_order` low (interleaved order) and `flow_thru` low (pipelined reads).

Top module: `sburst_sram`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `rvalid` is 0 and `rdata` is 0, and the burst step count is 0.
- R2: In a cycle with `ce` high and either `strobe_a` or `strobe_b` high, the access uses `addr` exactly, and the burst step count restarts from 0 with `addr` held as the new burst base.
- R3: In a cycle with `ce` high and neither strobe high, the access uses the burst base. Its two low bits are replaced by the burst offset. The step count first increments (mod 4) if `adv` is high and otherwise holds. With `ce` low, no access happens, no write occurs, and the base and step count are held.
- R4: With `lin_order` = 1, the two low address bits of a burst access equal (base[1:0] + step) mod 4.
- R5: With `lin_order` = 0, the two low address bits of a burst access equal base[1:0] XOR step.
- R6: `glob_we` high writes all byte lanes from `wdata`, whatever `byte_we` and `byte_sel` are.
- R7: With `glob_we` low and `byte_we` high, byte lane i (bits 8i+7..8i) is written only when `byte_sel[i]` is 1, and the other lanes keep their contents. With `byte_we` low, `byte_sel` has no effect.
- R8: A cycle started by `strobe_a` is always a read, and its write controls are ignored. A cycle started by `strobe_b`, or a burst continuation, obeys the write controls.
- R9: With `flow_thru` = 1, a read sampled at edge k presents its data on `rdata` with `rvalid` = 1 between edge k and edge k+1.
- R10: With `flow_thru` = 0, a read sampled at edge k presents its data between edge k+1 and edge k+2.
- R11: While `oe` is low, `rvalid` is 0 and `rdata` is 0 in the same cycle, without waiting for a clock edge.
- R12: A write cycle, or a cycle with `ce` low, presents no read data in the slot where a read's data would appear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge samples all synchronous inputs |
| rst_n | input | 1 | Active-low asynchronous reset of control state |
| ce | input | 1 | Chip enable; low cycles perform no access |
| addr | input | ADDR_W | External word address |
| strobe_a | input | 1 | Burst start strobe that forces a read cycle |
| strobe_b | input | 1 | Burst start strobe that obeys write controls |
| adv | input | 1 | Advance burst step count this cycle |
| lin_order | input | 1 | 1 = linear burst order, 0 = interleaved |
| flow_thru | input | 1 | 1 = flow-through reads, 0 = pipelined reads |
| wdata | input | DATA_W | Write data |
| byte_we | input | 1 | Byte-write enable, qualified by byte_sel |
| byte_sel | input | LANES | Per-lane select for byte writes |
| glob_we | input | 1 | Global write of all lanes |
| oe | input | 1 | Asynchronous output enable |
| rdata | output | DATA_W | Read data, zero when not valid |
| rvalid | output | 1 | Read data present on rdata |

## Verification
Writes and the burst base and step count take effect at the sampling edge, so their results can be seen from the next access on. Read data is due in the cycle after the sampling edge in flow-through mode and one cycle later in pipelined mode. Output enable acts within the same cycle. The bench keeps a reference memory and burst model that updates at each edge. It pushes the expected read result of each access into a two-slot queue, and at the falling edge it compares the outputs against the slot that the current latency mode selects. The output-enable check changes `oe` in mid-cycle and samples one time step later.

// File: rtl/sburst_pkg.sv
package sburst_pkg;

  // Low two address bits of a burst access for a given start offset and step.
  function automatic logic [1:0] burst_low(input logic [1:0] start,
                                           input logic [1:0] step,
                                           input logic       linear);
    logic [1:0] res;
    if (linear) res = start + step;
    else        res = start ^ step;
    return res;
  endfunction

endpackage

// File: rtl/sburst_addr_ctl.sv
module sburst_addr_ctl #(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce,
  input  logic [ADDR_W-1:0] addr,
  input  logic              load,
  input  logic              adv,
  input  logic              lin_order,
  output logic [ADDR_W-1:0] acc_addr,
  output logic [1:0]        burst_cnt
);
  import sburst_pkg::*;

  localparam int HI_W = ADDR_W - 2;

  logic [ADDR_W-1:0] base_q;
  logic [1:0]        cnt_eff;
  logic [ADDR_W-1:0] base_eff;

  always_comb begin
    if (load) begin
      base_eff = addr;
      cnt_eff  = 2'd0;
    end else begin
      base_eff = base_q;
      cnt_eff  = burst_cnt + {1'b0, adv};
    end
  end

  assign acc_addr = {base_eff[ADDR_W-1 -: HI_W],
                     burst_low(base_eff[1:0], cnt_eff, lin_order)};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q    <= '0;
      burst_cnt <= 2'd0;
    end else if (ce) begin
      base_q    <= base_eff;
      burst_cnt <= cnt_eff;
    end
  end

endmodule

// File: rtl/sburst_wr_dec.sv
module sburst_wr_dec #(
  parameter int LANES = 4
) (
  input  logic             ce,
  input  logic             strobe_a,
  input  logic             glob_we,
  input  logic             byte_we,
  input  logic [LANES-1:0] byte_sel,
  output logic [LANES-1:0] lane_mask
);
  logic wr_allowed;

  assign wr_allowed = ce && !strobe_a;

  always_comb begin
    lane_mask = '0;
    if (wr_allowed) begin
      if (glob_we)      lane_mask = '1;
      else if (byte_we) lane_mask = byte_sel;
    end
  end

endmodule

// File: rtl/sburst_array.sv
module sburst_array #(
  parameter int ADDR_W = 6,
  parameter int BYTE_W = 8,
  parameter int LANES  = 4
) (
  input  logic                    clk,
  input  logic [LANES-1:0]        lane_mask,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [LANES*BYTE_W-1:0] wdata,
  input  logic [ADDR_W-1:0]       rd_addr,
  output logic [LANES*BYTE_W-1:0] rd_word
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [BYTE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (lane_mask[g]) mem[wr_addr] <= wdata[g*BYTE_W +: BYTE_W];
    end

    assign rd_word[g*BYTE_W +: BYTE_W] = mem[rd_addr];
  end

endmodule

// File: rtl/sburst_rd_path.sv
module sburst_rd_path #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              flow_thru,
  input  logic              oe,
  output logic [ADDR_W-1:0] rd_addr_q,
  input  logic [DATA_W-1:0] rd_word,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);
  logic              rd_v_q;
  logic              pipe_v_q;
  logic [DATA_W-1:0] pipe_q;
  logic              sel_v;
  logic [DATA_W-1:0] sel_d;

  // Stage 1: address and valid captured at the sampling edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_v_q    <= 1'b0;
      rd_addr_q <= '0;
    end else begin
      rd_v_q    <= rd_en;
      rd_addr_q <= acc_addr;
    end
  end

  // Stage 2: output register used by the pipelined mode.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_v_q <= 1'b0;
    else        pipe_v_q <= rd_v_q;
  end

  always_ff @(posedge clk) begin
    pipe_q <= rd_word;
  end

  always_comb begin
    if (flow_thru) begin
      sel_v = rd_v_q;
      sel_d = rd_word;
    end else begin
      sel_v = pipe_v_q;
      sel_d = pipe_q;
    end
  end

  assign rvalid = oe && sel_v;
  assign rdata  = rvalid ? sel_d : '0;

endmodule

// File: rtl/sburst_sram.sv
module sburst_sram #(
  parameter int ADDR_W = 6,
  parameter int BYTE_W = 8,
  parameter int LANES  = 4,
  localparam int DATA_W = BYTE_W * LANES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce,
  input  logic [ADDR_W-1:0] addr,
  input  logic              strobe_a,
  input  logic              strobe_b,
  input  logic              adv,
  input  logic              lin_order,
  input  logic              flow_thru,
  input  logic [DATA_W-1:0] wdata,
  input  logic              byte_we,
  input  logic [LANES-1:0]  byte_sel,
  input  logic              glob_we,
  input  logic              oe,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);
  logic              load;
  logic [ADDR_W-1:0] acc_addr;
  logic [1:0]        burst_cnt;
  logic [LANES-1:0]  lane_mask;
  logic              rd_en;
  logic [ADDR_W-1:0] rd_addr_q;
  logic [DATA_W-1:0] rd_word;

  assign load  = ce && (strobe_a || strobe_b);
  assign rd_en = ce && (lane_mask == '0);

  sburst_addr_ctl #(.ADDR_W(ADDR_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .ce(ce), .addr(addr), .load(load), .adv(adv),
    .lin_order(lin_order), .acc_addr(acc_addr), .burst_cnt(burst_cnt)
  );

  sburst_wr_dec #(.LANES(LANES)) u_wdec (
    .ce(ce), .strobe_a(strobe_a), .glob_we(glob_we), .byte_we(byte_we),
    .byte_sel(byte_sel), .lane_mask(lane_mask)
  );

  sburst_array #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .LANES(LANES)) u_mem (
    .clk(clk), .lane_mask(lane_mask), .wr_addr(acc_addr), .wdata(wdata),
    .rd_addr(rd_addr_q), .rd_word(rd_word)
  );

  sburst_rd_path #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .acc_addr(acc_addr),
    .flow_thru(flow_thru), .oe(oe), .rd_addr_q(rd_addr_q), .rd_word(rd_word),
    .rdata(rdata), .rvalid(rvalid)
  );

endmodule

// File: rtl/sburst_sram_chk.sv
module sburst_sram_chk #(
  parameter int LANES  = 4,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ce,
  input logic              strobe_a,
  input logic              strobe_b,
  input logic              adv,
  input logic              glob_we,
  input logic              flow_thru,
  input logic              oe,
  input logic [LANES-1:0]  lane_mask,
  input logic [1:0]        burst_cnt,
  input logic [DATA_W-1:0] rdata,
  input logic              rvalid
);

  a_r1_rst_quiet: assert property (@(posedge clk)
    !rst_n |-> !rvalid && rdata == '0 && burst_cnt == 2'd0);

  a_r2_load_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    ce && (strobe_a || strobe_b) |=> burst_cnt == 2'd0);

  a_r3_hold_without_adv: assert property (@(posedge clk) disable iff (!rst_n)
    ce && !strobe_a && !strobe_b && !adv |=> $stable(burst_cnt));

  a_r3_ce_low_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |=> $stable(burst_cnt));

  a_r3_ce_low_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |-> lane_mask == '0);

  a_r6_global_all_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    ce && glob_we && !strobe_a |-> &lane_mask);

  a_r8_strobe_a_reads: assert property (@(posedge clk) disable iff (!rst_n)
    ce && strobe_a |-> lane_mask == '0);

  a_r11_oe_releases: assert property (@(posedge clk) disable iff (!rst_n)
    !oe |-> !rvalid && rdata == '0);

  a_r12_write_no_flow_data: assert property (@(posedge clk) disable iff (!rst_n)
    ce && (lane_mask != '0) && flow_thru |=> !flow_thru || !rvalid);

endmodule

bind sburst_sram sburst_sram_chk #(.LANES(LANES), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ce(ce), .strobe_a(strobe_a), .strobe_b(strobe_b),
  .adv(adv), .glob_we(glob_we), .flow_thru(flow_thru), .oe(oe),
  .lane_mask(lane_mask), .burst_cnt(burst_cnt), .rdata(rdata), .rvalid(rvalid)
);

// File: tb/sburst_sram_tb.sv
module sburst_sram_tb;
  localparam int AW = 6;
  localparam int DW = 32;
  localparam int NL = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ce = 1'b0, strobe_a = 1'b0, strobe_b = 1'b0, adv = 1'b0;
  logic          lin_order = 1'b0, flow_thru = 1'b0, oe = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic          byte_we = 1'b0, glob_we = 1'b0;
  logic [NL-1:0] byte_sel = '0;
  logic [DW-1:0] rdata;
  logic          rvalid;

  sburst_sram #(.ADDR_W(AW), .BYTE_W(8), .LANES(NL)) u_dut (
    .clk(clk), .rst_n(rst_n), .ce(ce), .addr(addr), .strobe_a(strobe_a),
    .strobe_b(strobe_b), .adv(adv), .lin_order(lin_order), .flow_thru(flow_thru),
    .wdata(wdata), .byte_we(byte_we), .byte_sel(byte_sel), .glob_we(glob_we),
    .oe(oe), .rdata(rdata), .rvalid(rvalid)
  );

  always #5 clk = ~clk;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // Reference model
  logic [DW-1:0] ref_mem [1 << AW];
  logic [AW-1:0] m_base = '0;
  logic [1:0]    m_cnt = 2'd0;
  logic          e1_v = 1'b0, e2_v = 1'b0;
  logic [DW-1:0] e1_d = '0, e2_d = '0;

  function automatic logic [AW-1:0] model_addr(input logic [AW-1:0] b,
                                               input logic [1:0] c, input logic lin);
    logic [1:0] lo;
    lo = lin ? 2'(b[1:0] + c) : (b[1:0] ^ c);
    return {b[AW-1:2], lo};
  endfunction

  function automatic logic [DW-1:0] merge(input logic [DW-1:0] old, input logic [DW-1:0] nw,
                                          input logic [NL-1:0] m);
    logic [DW-1:0] r;
    r = old;
    for (int i = 0; i < NL; i++) if (m[i]) r[i*8 +: 8] = nw[i*8 +: 8];
    return r;
  endfunction

  task automatic check(input string tag, input logic [DW-1:0] got_d, input logic got_v,
                       input logic [DW-1:0] exp_d, input logic exp_v);
    total++;
    if (got_v !== exp_v || got_d !== exp_d) begin
      bad++;
      $display("FAIL %s: rvalid=%0b rdata=%08h expected rvalid=%0b rdata=%08h",
               tag, got_v, got_d, exp_v, exp_d);
    end
  endtask

  // One access: drive at the falling edge, model at the rising edge, check at next falling edge.
  task automatic step(input logic c, input logic sa, input logic sb, input logic av,
                      input logic gw, input logic bw, input logic [NL-1:0] sel,
                      input logic [AW-1:0] a, input logic [DW-1:0] wd, input string tag);
    logic          ld;
    logic [1:0]    ce_cnt;
    logic [AW-1:0] ce_base, acc;
    logic [NL-1:0] m;
    logic          rd;
    logic [DW-1:0] rd_d;
    logic          xv;
    logic [DW-1:0] xd;
    ce = c; strobe_a = sa; strobe_b = sb; adv = av; glob_we = gw; byte_we = bw;
    byte_sel = sel; addr = a; wdata = wd;
    ld      = c && (sa || sb);
    ce_base = ld ? a : m_base;
    ce_cnt  = ld ? 2'd0 : 2'(m_cnt + {1'b0, av});
    acc     = model_addr(ce_base, ce_cnt, lin_order);
    m       = (c && !sa) ? (gw ? {NL{1'b1}} : (bw ? sel : '0)) : '0;
    rd      = c && (m == '0);
    rd_d    = ref_mem[acc];
    @(posedge clk);
    if (c) begin
      m_base = ce_base;
      m_cnt  = ce_cnt;
      if (m != '0) ref_mem[acc] = merge(ref_mem[acc], wd, m);
    end
    e2_v = e1_v; e2_d = e1_d;
    e1_v = rd;   e1_d = rd_d;
    @(negedge clk);
    xv = oe && (flow_thru ? e1_v : e2_v);
    xd = xv ? (flow_thru ? e1_d : e2_d) : '0;
    check(tag, rdata, rvalid, xd, xv);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, '0, '0, '0, tag);
  endtask

  // Strobe in a base and walk a full burst, with one held cycle.
  task automatic burst(input logic [AW-1:0] b, input logic use_a, input string tag);
    step(1, use_a, !use_a, 0, 0, 0, '0, b, '0, tag);
    step(1, 0, 0, 1, 0, 0, '0, '0, '0, tag);
    step(1, 0, 0, 0, 0, 0, '0, '0, '0, "R3");
    step(1, 0, 0, 1, 0, 0, '0, '0, '0, tag);
    step(1, 0, 0, 1, 0, 0, '0, '0, '0, tag);
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < (1 << AW); i++) ref_mem[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset", rdata, rvalid, '0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", rdata, rvalid, '0, 1'b0);

    // Fill the array with address-tagged words using global writes (R6, R12 slots).
    for (int i = 0; i < (1 << AW); i++)
      step(1, 0, 1, 0, 1, 0, 4'b0000, AW'(i), {8'hA5, 8'(i), 8'h3C, 8'(i ^ 8'hFF)}, "R6 R12");
    idle(2, "R12");

    // Bursts from every start offset, both orders, both strobes, both latencies.
    for (int f = 0; f < 2; f++) begin
      flow_thru = f[0];
      for (int o = 0; o < 2; o++) begin
        lin_order = o[0];
        for (int s = 0; s < 4; s++)
          burst(AW'(8 + s + 4 * o), s[0], o[0] ? (f[0] ? "R4 R9" : "R4 R10") : (f[0] ? "R5 R9" : "R5 R10"));
      end
      idle(2, "R12");
    end

    // R2: a new address strobed every cycle, no bursts used.
    flow_thru = 1'b0;
    for (int i = 0; i < 6; i++) step(1, i[0], !i[0], 1, 0, 0, '0, AW'(3 * i + 1), '0, "R2");
    // R3: chip enable low mid-burst ignores strobe, advance and writes.
    lin_order = 1'b1;
    step(1, 0, 1, 0, 0, 0, '0, AW'(21), '0, "R3");
    step(0, 1, 0, 1, 1, 0, '0, AW'(40), 32'hDEAD_BEEF, "R3 ce low");
    step(1, 0, 0, 1, 0, 0, '0, '0, '0, "R3 resume");
    step(1, 0, 0, 1, 0, 0, '0, '0, '0, "R3 resume");
    step(1, 1, 0, 0, 0, 0, '0, AW'(40), '0, "R3 ce low no write");

    // R7: byte writes and ignored selects.
    step(1, 0, 1, 0, 1, 0, '0, AW'(5), 32'h1122_3344, "R7");
    step(1, 0, 1, 0, 0, 1, 4'b0101, AW'(5), 32'hAABB_CCDD, "R7");
    step(1, 0, 1, 0, 0, 0, 4'b1111, AW'(5), 32'h5555_5555, "R7 sel ignored");
    step(1, 1, 0, 0, 0, 0, '0, AW'(5), '0, "R7 readback");
    idle(2, "R7");
    check("R7 byte merge", ref_mem[5], 1'b1, 32'h11BB_33DD, 1'b1);
    // R6: global write overrides selects and byte enable.
    step(1, 0, 1, 0, 1, 1, 4'b0001, AW'(6), 32'h0F0E_0D0C, "R6");
    step(1, 1, 0, 0, 0, 0, '0, AW'(6), '0, "R6 readback");
    idle(2, "R6");
    // R8: strobe_a ignores write controls; strobe_b obeys them.
    step(1, 1, 0, 0, 1, 1, 4'b1111, AW'(7), 32'h7777_7777, "R8 strobe_a read");
    step(1, 0, 1, 0, 1, 0, '0, AW'(7), 32'h8888_8888, "R8 strobe_b write");
    step(1, 1, 0, 0, 0, 0, '0, AW'(7), '0, "R8 readback");
    idle(2, "R8");

    // R11: output enable acts within the cycle.
    flow_thru = 1'b1;
    step(1, 1, 0, 0, 0, 0, '0, AW'(9), '0, "R9");
    oe = 1'b0; #1;
    check("R11 oe low", rdata, rvalid, '0, 1'b0);
    oe = 1'b1; #1;
    check("R11 oe back", rdata, rvalid, ref_mem[9], 1'b1);
    idle(1, "R12");

    // Random mix.
    for (int i = 0; i < 600; i++) begin
      if (i % 40 == 0) begin
        lin_order = 1'($urandom);
        flow_thru = 1'($urandom);
      end
      oe = ($urandom % 10) != 0;
      step(($urandom % 10) != 0, ($urandom % 4) == 0, ($urandom % 4) == 0,
           1'($urandom), ($urandom % 7) == 0, ($urandom % 3) == 0, 4'($urandom),
           AW'($urandom), $urandom, flow_thru ? "R9 random" : "R10 random");
    end
    oe = 1'b1;
    idle(3, "R12");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule